// File: doc/BRIEF.md
# Line-Doubled Monochrome Scanline Serializer

This block turns a frame buffer packed one bit per pixel into the serial pixel stream of a raster display. A raster timing generator gives it a line-start strobe, the index of the current display line and a flag that marks the active (visible) lines. On a strobe for a visible line, the block reads a fixed burst of 16-bit words from a synchronous-read frame-buffer memory, starting at the current row address. It shifts the words out one pixel every two system clocks, with the least significant bit of each word first.

Each frame-buffer row is shown on two display lines in a row, so a buffer of N rows fills 2N display lines. The burst is one word longer than the visible data. That last word is always zero, so the pixel line falls back to dark before blanking. Colour expansion and sync generation happen elsewhere.

Control is a three-state machine. `SCAN_IDLE` waits for a qualified strobe (transition *launch*). `SCAN_ARM` waits for the first word to come back from memory (transition *prime*, to `SCAN_RUN`). `SCAN_RUN` shifts pixels and prefetches the next word, and returns to `SCAN_IDLE` once the padding word has been shifted out (transition *drain*). A qualified strobe in `SCAN_ARM` or `SCAN_RUN` starts the burst again in `SCAN_ARM` (transition *restart*).

Top module: `rowpair_scanout`

## Requirements
- R1: While reset is held and after its release with no strobe, `pix_out` and `rd_en` are 0.
- R2: A qualified strobe makes the block read consecutive addresses, starting at the current row address and increasing by 1 per read, with `rd_en` high for exactly one cycle per read.
- R3: The first pixel appears on `pix_out` after the second rising edge that follows the edge at which the strobe was sampled. Words go out in address order, and within a word bit 0 goes first and bit 15 last.
- R4: Each pixel is held for exactly two system clocks, and there is no gap between words.
- R5: The last word of every burst is forced to zero without being read, and `pix_out` stays 0 after the burst ends.
- R6: A qualified strobe on a line whose offset from `FIRST_LINE` is odd advances the row address by `STRIDE` after that burst starts. On an even offset the row address is kept, so every row is shown twice.
- R7: After the second line of row `ROWS-1`, the row address wraps back to `FB_BASE`.
- R8: A strobe with `line_act` low, or with `line_idx` below `FIRST_LINE`, resets the row address to `FB_BASE`. It issues no read and starts no pixels.
- R9: A qualified strobe during a burst abandons that burst. A read still in flight is discarded, and the new burst starts from its first word at the row address for the new line.
- R10: The burst length is ((`WIDTH_PIX`/8)+2)/2 words, of which all but the last are read from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the pixel rate is half of it |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_go | input | 1 | One-cycle line-start strobe from the timing generator |
| line_idx | input | LINE_W | Index of the current display line |
| line_act | input | 1 | High while the current line is in the visible range |
| rd_en | output | 1 | Frame-buffer read enable |
| rd_addr | output | ADDR_W | Frame-buffer word address |
| rd_data | input | 16 | Read data, valid the cycle after the memory samples `rd_en` |
| pix_out | output | 1 | Serial pixel bit, 1 = lit |

## Verification
The hardest case to reach is a restart strobe that arrives in the exact cycle in which a prefetch read is still in flight. If the design does not discard that read, the first word of the new burst silently becomes stale data. The abort scenario counts clock edges from the first strobe so that the second strobe lands one edge after the word-2 prefetch is issued. It then compares the whole restarted pixel stream, and the read addresses, against the new row. Row doubling and the wrap past the last row are reached by walking a short frame of consecutive line strobes through a three-row buffer.

// File: rtl/rowpair_pkg.sv
package rowpair_pkg;

    localparam int WORD_W = 16;
    localparam int BIT_W  = 4;

    typedef enum logic [1:0] {
        SCAN_IDLE = 2'd0,
        SCAN_ARM  = 2'd1,
        SCAN_RUN  = 2'd2
    } scan_state_e;

    // Words per line burst: visible bytes plus two, in halfwords.
    function automatic int burst_words(input int width_pix);
        return ((width_pix / 8) + 2) / 2;
    endfunction

endpackage

// File: rtl/rowpair_rowptr.sv
module rowpair_rowptr #(
    parameter int ADDR_W     = 16,
    parameter int FIRST_LINE = 16,
    parameter int ROWS       = 240,
    parameter int STRIDE     = 40,
    parameter logic [ADDR_W-1:0] FB_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              line_ok,
    input  logic              line_lsb,
    output logic [ADDR_W-1:0] row_base
);

    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam logic [ROW_W-1:0]  LAST_ROW  = ROW_W'(ROWS - 1);
    localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(STRIDE);
    localparam logic              FIRST_ODD = ((FIRST_LINE % 2) != 0);

    logic [ROW_W-1:0] row_idx;
    logic             rel_odd;

    // Parity of the line offset from the first visible line.
    assign rel_odd = line_lsb ^ FIRST_ODD;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_idx  <= '0;
            row_base <= FB_BASE;
        end else if (go) begin
            if (!line_ok) begin
                row_idx  <= '0;
                row_base <= FB_BASE;
            end else if (rel_odd) begin
                if (row_idx == LAST_ROW) begin
                    row_idx  <= '0;
                    row_base <= FB_BASE;
                end else begin
                    row_idx  <= row_idx + 1'b1;
                    row_base <= row_base + STEP;
                end
            end
        end
    end

    p_blank_rewind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !line_ok) |=> (row_base == FB_BASE));

    p_even_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (go && line_ok && !rel_odd) |=> $stable(row_base));

endmodule

// File: rtl/rowpair_fetch.sv
module rowpair_fetch
    import rowpair_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BURST  = 41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] row_base,
    input  logic              word_end,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              load_first,
    output logic              load_zero,
    output logic              clr,
    output logic              shift_en,
    output logic              hold_we,
    output logic              busy
);

    localparam int CNT_W = $clog2(BURST + 1);
    localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(BURST - 1);
    localparam logic [CNT_W-1:0] PAD_PREV  = CNT_W'(BURST - 2);
    localparam logic [CNT_W-1:0] PF_LIMIT  = CNT_W'(BURST - 3);

    scan_state_e      state_q, state_d;
    logic [CNT_W-1:0] word_cnt;
    logic             rd_vld;
    logic             last_word;
    logic             issue;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCAN_IDLE: if (start) state_d = SCAN_ARM;
            SCAN_ARM: begin
                if (start)       state_d = SCAN_ARM;
                else if (rd_vld) state_d = SCAN_RUN;
            end
            SCAN_RUN: begin
                if (start)                       state_d = SCAN_ARM;
                else if (word_end && last_word)  state_d = SCAN_IDLE;
            end
            default: state_d = SCAN_IDLE;
        endcase
    end

    // Control outputs.
    always_comb begin
        shift_en   = (state_q == SCAN_RUN);
        busy       = (state_q != SCAN_IDLE);
        last_word  = (word_cnt == LAST_WORD);
        load_first = (state_q == SCAN_ARM) && rd_vld && !start;
        load_zero  = (word_cnt == PAD_PREV);
        clr        = start || (shift_en && word_end && last_word);
        hold_we    = shift_en && rd_vld;
        issue      = load_first ||
                     (shift_en && word_end && !last_word && (word_cnt < PF_LIMIT));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SCAN_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_en    <= 1'b0;
            rd_addr  <= '0;
            rd_vld   <= 1'b0;
            word_cnt <= '0;
        end else if (start) begin
            rd_en    <= 1'b1;
            rd_addr  <= row_base;
            rd_vld   <= 1'b0;
            word_cnt <= '0;
        end else begin
            rd_vld <= rd_en;
            rd_en  <= issue;
            if (issue) rd_addr <= rd_addr + 1'b1;
            if (load_first)
                word_cnt <= '0;
            else if (shift_en && word_end && !last_word)
                word_cnt <= word_cnt + 1'b1;
        end
    end

    p_read_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> busy);

    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        word_cnt <= LAST_WORD);

endmodule

// File: rtl/rowpair_shift.sv
module rowpair_shift
    import rowpair_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load_first,
    input  logic              load_zero,
    input  logic              shift_en,
    input  logic              hold_we,
    input  logic [WORD_W-1:0] rd_data,
    output logic              word_end,
    output logic              pix
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    logic [WORD_W-1:0] sh;
    logic [WORD_W-1:0] hold;
    logic              phase;
    logic [BIT_W-1:0]  bit_cnt;

    assign word_end = shift_en && phase && (bit_cnt == LAST_BIT);
    assign pix      = sh[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            hold    <= '0;
            phase   <= 1'b0;
            bit_cnt <= '0;
        end else begin
            if (hold_we) hold <= rd_data;
            if (clr) begin
                sh      <= '0;
                phase   <= 1'b0;
                bit_cnt <= '0;
            end else if (load_first) begin
                sh      <= rd_data;
                phase   <= 1'b0;
                bit_cnt <= '0;
            end else if (shift_en) begin
                phase <= ~phase;
                if (phase) begin
                    if (bit_cnt == LAST_BIT) begin
                        bit_cnt <= '0;
                        sh      <= load_zero ? '0 : hold;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        sh      <= sh >> 1;
                    end
                end
            end
        end
    end

    p_pix_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !phase && !clr && !load_first) |=> $stable(pix));

endmodule

// File: rtl/rowpair_scanout.sv
module rowpair_scanout
    import rowpair_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LINE_W     = 10,
    parameter int WIDTH_PIX  = 640,
    parameter int STRIDE     = 40,
    parameter int ROWS       = 240,
    parameter int FIRST_LINE = 16,
    parameter logic [ADDR_W-1:0] FB_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_go,
    input  logic [LINE_W-1:0] line_idx,
    input  logic              line_act,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [15:0]       rd_data,
    output logic              pix_out
);

    localparam int BURST = burst_words(WIDTH_PIX);

    logic              line_ok;
    logic              start;
    logic [ADDR_W-1:0] row_base;
    logic              word_end;
    logic              load_first;
    logic              load_zero;
    logic              clr;
    logic              shift_en;
    logic              hold_we;
    logic              busy;

    assign line_ok = line_act && (line_idx >= LINE_W'(FIRST_LINE));
    assign start   = scan_go && line_ok;

    rowpair_rowptr #(
        .ADDR_W    (ADDR_W),
        .FIRST_LINE(FIRST_LINE),
        .ROWS      (ROWS),
        .STRIDE    (STRIDE),
        .FB_BASE   (FB_BASE)
    ) u_rowptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (scan_go),
        .line_ok (line_ok),
        .line_lsb(line_idx[0]),
        .row_base(row_base)
    );

    rowpair_fetch #(
        .ADDR_W(ADDR_W),
        .BURST (BURST)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .row_base  (row_base),
        .word_end  (word_end),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .load_first(load_first),
        .load_zero (load_zero),
        .clr       (clr),
        .shift_en  (shift_en),
        .hold_we   (hold_we),
        .busy      (busy)
    );

    rowpair_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .load_first(load_first),
        .load_zero (load_zero),
        .shift_en  (shift_en),
        .hold_we   (hold_we),
        .rd_data   (rd_data),
        .word_end  (word_end),
        .pix       (pix_out)
    );

    p_idle_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pix_out);

endmodule

// File: tb/rowpair_scanout_bench.sv
module rowpair_scanout_bench;

    localparam int ADDR_W     = 8;
    localparam int LINE_W     = 6;
    localparam int WIDTH_PIX  = 64;
    localparam int STRIDE     = 6;
    localparam int ROWS       = 3;
    localparam int FIRST_LINE = 2;
    localparam int BASE       = 8;
    localparam int BURST      = ((WIDTH_PIX / 8) + 2) / 2;   // R10: 5 words

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              scan_go = 1'b0;
    logic [LINE_W-1:0] line_idx = '0;
    logic              line_act = 1'b0;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [15:0]       rd_data = '0;
    logic              pix_out;

    int n_total = 0;
    int n_fail  = 0;
    int rd_total = 0;
    logic [ADDR_W-1:0] rd_log [256];

    always #10 clk = ~clk;   // 50 MHz

    rowpair_scanout #(
        .ADDR_W    (ADDR_W),
        .LINE_W    (LINE_W),
        .WIDTH_PIX (WIDTH_PIX),
        .STRIDE    (STRIDE),
        .ROWS      (ROWS),
        .FIRST_LINE(FIRST_LINE),
        .FB_BASE   (ADDR_W'(BASE))
    ) u_rowpair_scanout (
        .clk     (clk),
        .rst_n   (rst_n),
        .scan_go (scan_go),
        .line_idx(line_idx),
        .line_act(line_act),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .pix_out (pix_out)
    );

    function automatic logic [15:0] fbw(input logic [ADDR_W-1:0] a);
        logic [15:0] t;
        t = {8'h00, a} * 16'h2F1B;
        return t ^ 16'h9C35;
    endfunction

    function automatic logic [15:0] exp_word(input int row, input int k);
        if (k == BURST - 1) return 16'h0000;
        return fbw(ADDR_W'(BASE + row * STRIDE + k));
    endfunction

    // Synchronous-read frame buffer and read monitor.
    always @(posedge clk) begin
        if (rd_en) begin
            rd_data <= fbw(rd_addr);
            rd_log[rd_total[7:0]] = rd_addr;
            rd_total = rd_total + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    int snap;

    // Drives a one-cycle strobe; returns at the negedge after the sampling edge.
    task automatic strobe(input int line, input bit act);
        @(negedge clk);
        scan_go  = 1'b1;
        line_idx = LINE_W'(line);
        line_act = act;
        @(negedge clk);
        scan_go  = 1'b0;
        snap     = rd_total;
    endtask

    task automatic check_stream(input int row, input string tag);
        int vis_err = 0, pad_err = 0, hold_err = 0;
        int fa = 0, fe = 0;
        bit first = 1'b1;
        @(negedge clk);
        for (int w = 0; w < BURST; w++) begin
            for (int b = 0; b < 16; b++) begin
                logic e, a, c;
                logic [15:0] ew;
                ew = exp_word(row, w);
                e = ew[b];
                @(negedge clk); a = pix_out;
                @(negedge clk); c = pix_out;
                if (a !== e) begin
                    if (w < BURST - 1) vis_err++; else pad_err++;
                    if (first) begin fa = a; fe = e; first = 1'b0; end
                end
                if (c !== a) hold_err++;
            end
        end
        chk(vis_err == 0, "R3", {tag, " visible pixels LSB first"}, fa, fe);
        chk(vis_err == 0, "R6", {tag, " row shown"}, vis_err, 0);
        chk(pad_err == 0, "R5", {tag, " padding word dark"}, pad_err, 0);
        chk(hold_err == 0, "R4", {tag, " two clocks per pixel"}, hold_err, 0);
        chk(rd_total - snap == BURST - 1, "R10", {tag, " reads per burst"},
            rd_total - snap, BURST - 1);
        begin
            int bad = 0;
            for (int i = 0; i < BURST - 1; i++)
                if (rd_log[(snap + i) % 256] != ADDR_W'(BASE + row * STRIDE + i)) bad++;
            chk(bad == 0, "R2", {tag, " read addresses"}, int'(rd_log[snap % 256]),
                BASE + row * STRIDE);
        end
        begin
            int lit = 0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (pix_out !== 1'b0) lit++;
            end
            chk(lit == 0, "R5", {tag, " dark after burst"}, lit, 0);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(pix_out === 1'b0, "R1", "pix in reset", int'(pix_out), 0);
        chk(rd_en === 1'b0, "R1", "rd_en in reset", int'(rd_en), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(pix_out === 1'b0 && rd_total == 0, "R1", "quiet after reset", rd_total, 0);
    endtask

    task automatic t_blank(input int line);
        int lit = 0;
        strobe(line, 1'b0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pix_out !== 1'b0) lit++;
        end
        chk(rd_total == snap, "R8", "blank strobe reads", rd_total - snap, 0);
        chk(lit == 0, "R8", "blank strobe pixels", lit, 0);
    endtask

    task automatic t_frame();
        t_blank(0);
        strobe(2, 1'b1); check_stream(0, "line2");
        strobe(3, 1'b1); check_stream(0, "line3");
        strobe(4, 1'b1); check_stream(1, "line4");
        strobe(5, 1'b1); check_stream(1, "line5");
        strobe(6, 1'b1); check_stream(2, "line6");
        strobe(7, 1'b1); check_stream(2, "line7");
        // R7: past the last row the pointer is back at the base
        strobe(8, 1'b1); check_stream(0, "R7 wrap line8");
    endtask

    task automatic t_rewind();
        strobe(9, 1'b1); check_stream(0, "line9");
        t_blank(30);
        // R8: blank strobe has rewound the pointer to row 0
        strobe(2, 1'b1); check_stream(0, "R8 after rewind");
        strobe(3, 1'b1); check_stream(0, "line3 again");
    endtask

    task automatic t_abort();
        strobe(5, 1'b1);             // row 1, pointer then advances to row 2
        repeat (33) @(negedge clk);  // next strobe lands one edge after word-2 prefetch
        strobe(6, 1'b1);
        check_stream(2, "R9 restart");
    endtask

    initial begin
        t_reset();
        t_frame();
        t_rewind();
        t_abort();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule